// File: doc/BRIEF.md
# Sample Coding and Output Drive Selector

This block sits between a converter core and its physical output stage. Each sample clock it takes one offset-binary sample and re-codes it into the selected output coding: offset binary passed through, two's complement, or Gray. The coded word is registered, so it appears one cycle after the sample is presented. Alongside the data, the block registers three select lines that tell the output stage whether to run as differential low-swing at low drive, differential low-swing at high drive, or single-ended CMOS.

Both choices come from one 8-bit configuration register, written over a simple register port. The coding field sits in bits 2:0 and the drive field in bits 7:5. Each field uses one-hot codes. A field value of zero, or any code that is not one-hot, hands that choice back to a tri-level strap pin. A soft reset clears the data path but leaves the register untouched. Only the hard reset clears the register.

Top module: `outfmt_sel`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `data_out` is 0 and `lvds_en`, `drv_hi` and `cmos_en` are all 0. The register clears, so both choices follow the pins afterwards.
- R2: `data_out` after a rising edge is the coded form of the `smp_in` present before that edge. This gives one cycle of latency.
- R3: Coding field `cfg_wdata[2:0]` = 3'b001 selects two's complement: the sample with its MSB inverted.
- R4: Coding field = 3'b010 selects Gray: `b ^ (b >> 1)` of the offset-binary sample.
- R5: Coding field = 3'b100 selects offset binary: the sample unchanged.
- R6: A coding field of 3'b000, or any value that is not one-hot, selects the coding from `fmt_pin`: 2'b00 (low) gives offset binary, 2'b01 (mid) gives two's complement, and 2'b1x (high) gives Gray.
- R7: Drive field `cfg_wdata[7:5]` sets `{lvds_en,drv_hi,cmos_en}` as follows: 3'b001 gives 3'b100 (low drive), 3'b010 gives 3'b110 (high drive), and 3'b100 gives 3'b001 (CMOS).
- R8: A drive field of 3'b000, or any value that is not one-hot, selects the drive from `mode_pin`: 2'b00 gives 3'b100, 2'b01 gives 3'b110, and 2'b1x gives 3'b001.
- R9: `soft_rst` high before an edge makes `data_out` 0 after it. The select lines and the register keep their settings.
- R10: A register write takes effect for the sample taken in the cycle after the write. A sample presented in the same cycle as the write is coded with the previous setting.
- R11: Outside reset, exactly one of `lvds_en` and `cmos_en` is high. `drv_hi` is never high without `lvds_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset; clears data only |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value (drive field 7:5, coding field 2:0) |
| fmt_pin | input | 2 | Tri-level coding strap: 00 low, 01 mid, 1x high |
| mode_pin | input | 2 | Tri-level drive strap: 00 low, 01 mid, 1x high |
| smp_in | input | W | Offset-binary sample |
| data_out | output | W | Registered coded sample |
| lvds_en | output | 1 | Differential output stage enabled |
| drv_hi | output | 1 | High differential drive level |
| cmos_en | output | 1 | Single-ended CMOS stage enabled |

## Verification
A register write can land in the same cycle as a sample that must be coded. A soft reset can also coincide with a write. The random phase provokes both collisions by raising `cfg_we` and `soft_rst` freely alongside every sample. Directed steps repeat the collisions with coding changes whose outputs differ visibly. The bench judges each collision by coding the sample with the register value held before the edge, and by applying the new value from the next sample on. A write during a soft reset must still be kept.

// File: rtl/outfmt_pkg.sv
package outfmt_pkg;

    localparam int REG_W    = 8;
    localparam int FIELD_W  = 3;
    localparam int FMT_LSB  = 0;
    localparam int DRV_LSB  = 5;
    localparam int PIN_W    = 2;

    typedef enum logic [1:0] {
        FMT_OFFS = 2'd0,
        FMT_TWOS = 2'd1,
        FMT_GRAY = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        DRV_LVDS_LO = 2'd0,
        DRV_LVDS_HI = 2'd1,
        DRV_CMOS    = 2'd2
    } drv_e;

    typedef struct packed {
        logic [FIELD_W-1:0] drv_f;
        logic [FIELD_W-1:0] fmt_f;
    } cfg_t;

    typedef struct packed {
        logic lvds_en;
        logic drv_hi;
        logic cmos_en;
    } drv_sel_t;

    localparam logic [FIELD_W-1:0] F_A = 3'b001;
    localparam logic [FIELD_W-1:0] F_B = 3'b010;
    localparam logic [FIELD_W-1:0] F_C = 3'b100;

    function automatic fmt_e fmt_from_pin(input logic [PIN_W-1:0] pin);
        if (pin[1])      return FMT_GRAY;
        else if (pin[0]) return FMT_TWOS;
        else             return FMT_OFFS;
    endfunction

    function automatic drv_e drv_from_pin(input logic [PIN_W-1:0] pin);
        if (pin[1])      return DRV_CMOS;
        else if (pin[0]) return DRV_LVDS_HI;
        else             return DRV_LVDS_LO;
    endfunction

    function automatic fmt_e fmt_resolve(input logic [FIELD_W-1:0] f,
                                         input logic [PIN_W-1:0]   pin);
        case (f)
            F_A:     return FMT_TWOS;
            F_B:     return FMT_GRAY;
            F_C:     return FMT_OFFS;
            default: return fmt_from_pin(pin);
        endcase
    endfunction

    function automatic drv_e drv_resolve(input logic [FIELD_W-1:0] f,
                                         input logic [PIN_W-1:0]   pin);
        case (f)
            F_A:     return DRV_LVDS_LO;
            F_B:     return DRV_LVDS_HI;
            F_C:     return DRV_CMOS;
            default: return drv_from_pin(pin);
        endcase
    endfunction

    function automatic drv_sel_t drv_decode(input drv_e d);
        drv_sel_t s;
        s = '0;
        case (d)
            DRV_LVDS_LO: s.lvds_en = 1'b1;
            DRV_LVDS_HI: begin s.lvds_en = 1'b1; s.drv_hi = 1'b1; end
            default:     s.cmos_en = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/outfmt_cfg_reg.sv
module outfmt_cfg_reg
    import outfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    cfg_t cfg_q;

    // Soft reset deliberately not connected: register survives it.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.fmt_f <= wdata[FMT_LSB +: FIELD_W];
            cfg_q.drv_f <= wdata[DRV_LSB +: FIELD_W];
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/outfmt_resolve.sv
module outfmt_resolve
    import outfmt_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [PIN_W-1:0] fmt_pin,
    input  logic [PIN_W-1:0] mode_pin,
    output fmt_e             fmt_eff,
    output drv_e             drv_eff
);
    always_comb begin
        fmt_eff = fmt_resolve(cfg.fmt_f, fmt_pin);
        drv_eff = drv_resolve(cfg.drv_f, mode_pin);
    end
endmodule

// File: rtl/outfmt_code_conv.sv
module outfmt_code_conv
    import outfmt_pkg::*;
#(
    parameter int W = 10
) (
    input  fmt_e         fmt,
    input  logic [W-1:0] smp,
    output logic [W-1:0] code
);
    logic [W-1:0] gray_w;
    logic [W-1:0] twos_w;

    genvar i;
    generate
        for (i = 0; i < W - 1; i++) begin : g_gray
            assign gray_w[i] = smp[i] ^ smp[i+1];
        end
    endgenerate
    assign gray_w[W-1] = smp[W-1];

    assign twos_w = {~smp[W-1], smp[W-2:0]};

    always_comb begin
        case (fmt)
            FMT_TWOS: code = twos_w;
            FMT_GRAY: code = gray_w;
            default:  code = smp;
        endcase
    end
endmodule

// File: rtl/outfmt_sel.sv
module outfmt_sel
    import outfmt_pkg::*;
#(
    parameter int W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic [PIN_W-1:0] fmt_pin,
    input  logic [PIN_W-1:0] mode_pin,
    input  logic [W-1:0]     smp_in,
    output logic [W-1:0]     data_out,
    output logic             lvds_en,
    output logic             drv_hi,
    output logic             cmos_en
);
    cfg_t         cfg;
    fmt_e         fmt_eff;
    drv_e         drv_eff;
    logic [W-1:0] coded;
    logic [W-1:0] data_q;
    drv_sel_t     drv_q;

    outfmt_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    outfmt_resolve u_res (
        .cfg      (cfg),
        .fmt_pin  (fmt_pin),
        .mode_pin (mode_pin),
        .fmt_eff  (fmt_eff),
        .drv_eff  (drv_eff)
    );

    outfmt_code_conv #(.W(W)) u_conv (
        .fmt  (fmt_eff),
        .smp  (smp_in),
        .code (coded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            drv_q  <= '0;
        end else begin
            drv_q  <= drv_decode(drv_eff);
            data_q <= soft_rst ? '0 : coded;
        end
    end

    assign data_out = data_q;
    assign lvds_en  = drv_q.lvds_en;
    assign drv_hi   = drv_q.drv_hi;
    assign cmos_en  = drv_q.cmos_en;
endmodule

// File: rtl/outfmt_sel_chk.sv
module outfmt_sel_chk
    import outfmt_pkg::*;
#(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         soft_rst,
    input logic [W-1:0] smp_in,
    input fmt_e         fmt_eff,
    input logic [W-1:0] data_out,
    input logic         lvds_en,
    input logic         drv_hi,
    input logic         cmos_en
);
    logic prev_rst = 1'b0;
    always_ff @(posedge clk) prev_rst <= rst;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (data_out == '0 && !lvds_en && !drv_hi && !cmos_en));

    assert_twos_R3: assert property (@(posedge clk) disable iff (rst)
        (fmt_eff == FMT_TWOS && !soft_rst) |=>
            data_out == {~$past(smp_in[W-1]), $past(smp_in[W-2:0])});

    assert_gray_R4: assert property (@(posedge clk) disable iff (rst)
        (fmt_eff == FMT_GRAY && !soft_rst) |=>
            data_out == ($past(smp_in) ^ ($past(smp_in) >> 1)));

    assert_offs_R5: assert property (@(posedge clk) disable iff (rst)
        (fmt_eff == FMT_OFFS && !soft_rst) |=> data_out == $past(smp_in));

    assert_soft_clear_R9: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> data_out == '0);

    assert_drive_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !prev_rst |-> ((lvds_en ^ cmos_en) && (!drv_hi || lvds_en)));
endmodule

bind outfmt_sel outfmt_sel_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .smp_in   (smp_in),
    .fmt_eff  (fmt_eff),
    .data_out (data_out),
    .lvds_en  (lvds_en),
    .drv_hi   (drv_hi),
    .cmos_en  (cmos_en)
);

// File: tb/outfmt_sel_tb.sv
module outfmt_sel_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         soft_rst = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_wdata = '0;
    logic [1:0]   fmt_pin = 2'b00;
    logic [1:0]   mode_pin = 2'b00;
    logic [W-1:0] smp_in = '0;
    logic [W-1:0] data_out;
    logic         lvds_en, drv_hi, cmos_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_cfg = '0;

    always #5 clk = ~clk;

    outfmt_sel #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .fmt_pin(fmt_pin), .mode_pin(mode_pin),
        .smp_in(smp_in), .data_out(data_out), .lvds_en(lvds_en),
        .drv_hi(drv_hi), .cmos_en(cmos_en)
    );

    // 0 offset, 1 two's, 2 Gray
    function automatic int exp_fmt(input logic [7:0] c, input logic [1:0] p);
        case (c[2:0])
            3'b001:  return 1;
            3'b010:  return 2;
            3'b100:  return 0;
            default: return p[1] ? 2 : (p[0] ? 1 : 0);
        endcase
    endfunction

    function automatic logic [2:0] exp_drv(input logic [7:0] c, input logic [1:0] p);
        case (c[7:5])
            3'b001:  return 3'b100;
            3'b010:  return 3'b110;
            3'b100:  return 3'b001;
            default: return p[1] ? 3'b001 : (p[0] ? 3'b110 : 3'b100);
        endcase
    endfunction

    function automatic logic [W-1:0] exp_code(input int f, input logic [W-1:0] b);
        if (f == 1)      return b ^ (1 << (W - 1));
        else if (f == 2) return b ^ (b >> 1);
        else             return b;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cycle(input string req, input logic [W-1:0] s,
                             input logic we, input logic [7:0] wd, input logic sr);
        logic [W-1:0] ed;
        logic [2:0]   em;
        @(negedge clk);
        smp_in = s; cfg_we = we; cfg_wdata = wd; soft_rst = sr;
        ed = sr ? '0 : exp_code(exp_fmt(m_cfg, fmt_pin), s);
        em = exp_drv(m_cfg, mode_pin);
        @(posedge clk); #1;
        check(req, data_out, ed);
        check(req, {{(W-3){1'b0}}, lvds_en, drv_hi, cmos_en}, {{(W-3){1'b0}}, em});
        if (we) m_cfg = wd;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cfg_we = 1'b0; soft_rst = 1'b0;
        @(posedge clk); #1;
        check("R1", data_out, '0);
        check("R1", {{(W-3){1'b0}}, lvds_en, drv_hi, cmos_en}, '0);
        @(negedge clk); rst = 1'b0; m_cfg = '0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (2) @(posedge clk);
        do_reset();
        // R1: register cleared, pins rule; R6/R8 pin paths
        fmt_pin = 2'b01; mode_pin = 2'b01;
        run_cycle("R1", 10'h3A5, 1'b0, 8'h00, 1'b0);
        fmt_pin = 2'b00; mode_pin = 2'b00;
        run_cycle("R6", 10'h200, 1'b0, 8'h00, 1'b0);
        fmt_pin = 2'b10; mode_pin = 2'b10;
        run_cycle("R8", 10'h2F3, 1'b0, 8'h00, 1'b0);
        fmt_pin = 2'b11; mode_pin = 2'b11;
        run_cycle("R6", 10'h155, 1'b0, 8'h00, 1'b0);
        // R10: write coincides with sample; old coding applies
        run_cycle("R10", 10'h3FF, 1'b1, 8'h21, 1'b0);
        run_cycle("R3", 10'h3FF, 1'b0, 8'h00, 1'b0);
        run_cycle("R3", 10'h000, 1'b0, 8'h00, 1'b0);
        run_cycle("R7", 10'h1AB, 1'b1, 8'h42, 1'b0);
        run_cycle("R4", 10'h1AB, 1'b0, 8'h00, 1'b0);
        run_cycle("R4", 10'h3FF, 1'b1, 8'h84, 1'b0);
        run_cycle("R5", 10'h2C3, 1'b0, 8'h00, 1'b0);
        run_cycle("R7", 10'h001, 1'b0, 8'h00, 1'b0);
        // R6/R8: non-one-hot fields fall back to pins
        fmt_pin = 2'b01; mode_pin = 2'b00;
        run_cycle("R6", 10'h111, 1'b1, 8'h63, 1'b0);
        run_cycle("R6", 10'h3C0, 1'b0, 8'h00, 1'b0);
        run_cycle("R8", 10'h0F0, 1'b1, 8'hE7, 1'b0);
        run_cycle("R8", 10'h0F0, 1'b0, 8'h00, 1'b0);
        // R9: soft reset keeps register
        run_cycle("R9", 10'h2AA, 1'b1, 8'h82, 1'b0);
        run_cycle("R9", 10'h2AA, 1'b0, 8'h00, 1'b1);
        run_cycle("R9", 10'h2AA, 1'b0, 8'h00, 1'b0);
        run_cycle("R9", 10'h133, 1'b1, 8'h41, 1'b1);
        run_cycle("R9", 10'h133, 1'b0, 8'h00, 1'b0);
        // R1: hard reset clears register
        do_reset();
        fmt_pin = 2'b00; mode_pin = 2'b10;
        run_cycle("R1", 10'h3AB, 1'b0, 8'h00, 1'b0);
        run_cycle("R1", 10'h3AB, 1'b0, 8'h00, 1'b0);
        // R2: random mix
        for (int k = 0; k < 600; k++) begin
            fmt_pin  = 2'($urandom);
            mode_pin = 2'($urandom);
            run_cycle("R2", W'($urandom), ($urandom % 4) == 0, 8'($urandom),
                      ($urandom % 13) == 0);
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule